// File: doc/BRIEF.md
# Programmable-Priority Vectored Interrupt Controller

The controller collects 24 level-sensitive interrupt inputs from peripherals. The inputs are 12 pin-driven sources and 12 on-chip sources. Each input can be masked. While any input is eligible, the controller raises one request line to the processor, chosen from eight levels by a configuration input.

The processor acknowledges a request by writing the acknowledge bit. On that write the controller loads a 5-bit vector code that names the winning source and marks that source as in service. The acknowledge bit drops again on its own one cycle later.

The priority order follows the source index, with two exceptions:
- Two designated sources form a pair: a serial channel and a USB channel. A swap bit sets which member of the pair ranks higher, and a scheme bit either leaves the pair in its own slots or lifts it above every other fixed source.
- A promote field can move any one source above all others.

Nesting uses in-service bits. While a source is in service, only sources that rank strictly above it can raise a new request. Software ends the service of a source by writing 1 to that source's clear bit.

Top module: `prio_vic`

## Requirements
- R1: After reset, irq_o is 0, vec_o is 0, iack_o is 0 and no source is in service.
- R2: irq_o is a one-hot vector with bit level_i set while at least one source is eligible, and is 0 when none is. A source is eligible when its src_i bit is 1, its mask_i bit is 0 (1 = masked), and it ranks strictly above every in-service source.
- R3: On a clock edge where iack_set_i is 1 and iack_o is 0, vec_o loads the code of the highest-ranked eligible source. Source index k has code k+1. Without overrides, a lower index ranks higher: source 0 is highest and source 23 is lowest.
- R4: iack_o is 1 for exactly the one cycle that follows an accepted acknowledge. An acknowledge write made while iack_o is 1 is ignored, and vec_o keeps its value.
- R5: If no source is eligible at an accepted acknowledge, vec_o loads the error code 0 and the in-service state does not change.
- R6: The pair is source 5 (serial) and source 6 (USB). With pair_swap_i = 0, source 5 ranks above source 6. With pair_swap_i = 1, source 6 ranks above source 5.
- R7: With pair_top_i = 0, the pair keeps slots 5 and 6 in the index order. With pair_top_i = 1, the pair ranks above every source other than a promoted one.
- R8: With promo_en_i = 1, the source whose index is promo_sel_i ranks above all other sources.
- R9: An accepted acknowledge with a winner puts the winner in service. Writing 1 to an isr_clr_i bit takes that source out of service. When an acknowledge sets a bit and a clear hits the same bit in the same cycle, the set wins.
- R10: vec_o changes only on an accepted acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 24 | Pending level per source |
| mask_i | input | 24 | 1 masks the source |
| level_i | input | 3 | Request level |
| pair_swap_i | input | 1 | Source 6 above source 5 when 1 |
| pair_top_i | input | 1 | Lift pair above fixed order when 1 |
| promo_en_i | input | 1 | Enable promoted source |
| promo_sel_i | input | 5 | Index of promoted source |
| iack_set_i | input | 1 | Processor write of the acknowledge bit |
| isr_clr_i | input | 24 | Write-1-to-clear of in-service bits |
| irq_o | output | 8 | One-hot request at the programmed level |
| iack_o | output | 1 | Acknowledge bit, self-clearing |
| vec_o | output | 5 | Latched vector code |

## Verification
Two functions can land on the same edge. An acknowledge can arrive together with an in-service clear, and the clear may target the very source the acknowledge is about to put in service, or a lower-ranked source whose clear should widen eligibility only from the next cycle.

The bench provokes these cases directly. A random stream also drives acknowledge strobes and clear masks that often coincide. After each edge, the bench compares the following vector codes and request lines with a model that applies set-over-clear and uses the pre-edge in-service state for the winner.

// File: rtl/prio_vic_pkg.sv
package prio_vic_pkg;
  localparam int N_SRC  = 24;
  localparam int N_LVL  = 8;
  localparam int SEL_W  = $clog2(N_SRC);
  localparam int VEC_W  = $clog2(N_SRC + 1);
  localparam int LVL_W  = $clog2(N_LVL);
  localparam int PAIR_A = 5;
  localparam int PAIR_B = 6;
  localparam int KEY_W  = 2 + SEL_W;

  typedef enum logic [1:0] {
    TIER_PROMO = 2'd0,
    TIER_PAIR  = 2'd1,
    TIER_FIXED = 2'd2
  } tier_e;

  typedef struct packed {
    tier_e            tier;
    logic [SEL_W-1:0] sub;
  } rank_key_t;
endpackage

// File: rtl/prio_vic_rank.sv
module prio_vic_rank
  import prio_vic_pkg::*;
#(
  parameter int NS = N_SRC
) (
  input  logic             pair_swap_i,
  input  logic             pair_top_i,
  input  logic             promo_en_i,
  input  logic [SEL_W-1:0] promo_sel_i,
  output rank_key_t        key_o [NS]
);
  for (genvar g = 0; g < NS; g++) begin : g_key
    always_comb begin
      key_o[g].tier = TIER_FIXED;
      key_o[g].sub  = SEL_W'(g);
      if (promo_en_i && promo_sel_i == SEL_W'(g)) begin
        key_o[g].tier = TIER_PROMO;
        key_o[g].sub  = '0;
      end else if (g == PAIR_A || g == PAIR_B) begin
        // upper slot goes to A unless swapped
        if (pair_top_i) begin
          key_o[g].tier = TIER_PAIR;
          key_o[g].sub  = SEL_W'(((g == PAIR_B) != pair_swap_i) ? 1 : 0);
        end else begin
          key_o[g].sub  = SEL_W'(((g == PAIR_B) != pair_swap_i) ? PAIR_B : PAIR_A);
        end
      end
    end
  end
endmodule

// File: rtl/prio_vic_min.sv
module prio_vic_min
  import prio_vic_pkg::*;
#(
  parameter int NS = N_SRC
) (
  input  logic [NS-1:0] req_i,
  input  rank_key_t     key_i [NS],
  output logic          any_o,
  output logic [SEL_W-1:0] idx_o,
  output rank_key_t     key_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    key_o = '{tier: TIER_FIXED, sub: '1};
    for (int i = 0; i < NS; i++) begin
      if (req_i[i] && (!any_o || key_i[i] < key_o)) begin
        any_o = 1'b1;
        idx_o = SEL_W'(i);
        key_o = key_i[i];
      end
    end
  end
endmodule

// File: rtl/prio_vic.sv
module prio_vic
  import prio_vic_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SRC-1:0]   src_i,
  input  logic [N_SRC-1:0]   mask_i,
  input  logic [LVL_W-1:0]   level_i,
  input  logic               pair_swap_i,
  input  logic               pair_top_i,
  input  logic               promo_en_i,
  input  logic [SEL_W-1:0]   promo_sel_i,
  input  logic               iack_set_i,
  input  logic [N_SRC-1:0]   isr_clr_i,
  output logic [N_LVL-1:0]   irq_o,
  output logic               iack_o,
  output logic [VEC_W-1:0]   vec_o
);
  rank_key_t        key [N_SRC];
  logic [N_SRC-1:0] isr_q, elig;
  logic             isr_any, win_any, ack_ok;
  logic [SEL_W-1:0] isr_idx, win_idx;
  rank_key_t        isr_key, win_key;

  prio_vic_rank #(.NS(N_SRC)) u_rank (
    .pair_swap_i (pair_swap_i),
    .pair_top_i  (pair_top_i),
    .promo_en_i  (promo_en_i),
    .promo_sel_i (promo_sel_i),
    .key_o       (key)
  );

  // highest in-service rank sets the nesting threshold
  prio_vic_min #(.NS(N_SRC)) u_isr_min (
    .req_i (isr_q),
    .key_i (key),
    .any_o (isr_any),
    .idx_o (isr_idx),
    .key_o (isr_key)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_elig
    assign elig[g] = src_i[g] & ~mask_i[g] & (~isr_any | (key[g] < isr_key));
  end

  prio_vic_min #(.NS(N_SRC)) u_win_min (
    .req_i (elig),
    .key_i (key),
    .any_o (win_any),
    .idx_o (win_idx),
    .key_o (win_key)
  );

  assign ack_ok = iack_set_i & ~iack_o;
  assign irq_o  = win_any ? (N_LVL'(1) << level_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iack_o <= 1'b0;
      vec_o  <= '0;
      isr_q  <= '0;
    end else begin
      iack_o <= ack_ok;
      if (ack_ok) vec_o <= win_any ? VEC_W'(win_idx) + VEC_W'(1) : '0;
      isr_q <= (isr_q & ~isr_clr_i) |
               ((ack_ok && win_any) ? (N_SRC'(1) << win_idx) : '0);
    end
  end
endmodule

// File: rtl/prio_vic_chk.sv
module prio_vic_chk
  import prio_vic_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_SRC-1:0]   src_i,
  input logic [N_SRC-1:0]   mask_i,
  input logic [LVL_W-1:0]   level_i,
  input logic               iack_set_i,
  input logic [N_LVL-1:0]   irq_o,
  input logic               iack_o,
  input logic [VEC_W-1:0]   vec_o
);
  logic [N_SRC-1:0] open_q;
  logic             req_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= '0;
      req_q  <= 1'b0;
    end else begin
      open_q <= src_i & ~mask_i;
      req_q  <= |irq_o;
    end
  end

  assert_iack_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iack_o |=> !iack_o);
  assert_irq_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o) && ((|irq_o) -> irq_o[level_i]));
  assert_vec_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iack_o |-> $stable(vec_o));
  assert_err_vec_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iack_o && vec_o == '0) |-> !req_q);
  assert_vec_open_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iack_o && vec_o != '0) |-> open_q[vec_o - VEC_W'(1)]);
  assert_ack_follows_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(iack_o) |-> $past(iack_set_i));
endmodule

bind prio_vic prio_vic_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_i      (src_i),
  .mask_i     (mask_i),
  .level_i    (level_i),
  .iack_set_i (iack_set_i),
  .irq_o      (irq_o),
  .iack_o     (iack_o),
  .vec_o      (vec_o)
);

// File: tb/prio_vic_bench.sv
module prio_vic_bench;
  import prio_vic_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N_SRC-1:0] src = '0, mask = '0, clr = '0;
  logic [LVL_W-1:0] lvl = '0;
  logic swp = 1'b0, top = 1'b0, pen = 1'b0, iset = 1'b0;
  logic [SEL_W-1:0] psel = '0;
  logic [N_LVL-1:0] irq;
  logic iack;
  logic [VEC_W-1:0] vec;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [N_SRC-1:0] m_isr = '0;
  logic m_iack = 1'b0;
  logic [VEC_W-1:0] m_vec = '0;

  always #2.5 clk = ~clk;

  prio_vic u_prio_vic (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .mask_i(mask), .level_i(lvl),
    .pair_swap_i(swp), .pair_top_i(top), .promo_en_i(pen), .promo_sel_i(psel),
    .iack_set_i(iset), .isr_clr_i(clr), .irq_o(irq), .iack_o(iack), .vec_o(vec)
  );

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // rank value from the requirements: smaller ranks higher
  function automatic int rank(int i);
    if (pen && int'(psel) == i) return 0;
    if (i == PAIR_A || i == PAIR_B) begin
      bit upper = (i == PAIR_A) ^ swp;
      if (top) return upper ? 1 : 2;
      return 10 + (upper ? PAIR_A : PAIR_B);
    end
    return 10 + i;
  endfunction

  function automatic int winner();
    int best = -1, thr = 1000;
    for (int i = 0; i < N_SRC; i++) if (m_isr[i] && rank(i) < thr) thr = rank(i);
    for (int i = 0; i < N_SRC; i++)
      if (src[i] && !mask[i] && rank(i) < thr && (best < 0 || rank(i) < rank(best))) best = i;
    return best;
  endfunction

  // one cycle: inputs already set; check comb request, clock, check registers
  task automatic cycle(string tag);
    int w;
    #1;
    w = winner();
    chk({"R2 irq ", tag}, irq, (w >= 0) ? (N_LVL'(1) << lvl) : 0);
    @(posedge clk);
    if (iset && !m_iack) m_vec = (w >= 0) ? VEC_W'(w + 1) : '0;
    m_isr = (m_isr & ~clr) | ((iset && !m_iack && w >= 0) ? (N_SRC'(1) << w) : '0);
    m_iack = iset && !m_iack;
    #1;
    chk({"R3 vec ", tag}, vec, m_vec);
    chk({"R4 iack ", tag}, iack, m_iack);
    @(negedge clk);
    iset = 0; clr = '0;
  endtask

  task automatic ack_vec(logic [N_SRC-1:0] s, string tag, int exp);
    src = s; iset = 1; cycle(tag);
    chk(tag, vec, exp);
    cycle({tag, " drop"});
    clr = '1; src = '0; cycle({tag, " clr"});
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 irq", irq, 0); chk("R1 vec", vec, 0); chk("R1 iack", iack, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    src = '1; cycle("R1 nothing in service");

    ack_vec('0, "R5 error vector", 0);
    ack_vec(24'h800001, "R3 default order", 1);
    ack_vec(24'h800000, "R3 lowest", 24);
    swp = 0; ack_vec(24'h000060, "R6 no swap", 6);
    swp = 1; ack_vec(24'h000060, "R6 swapped", 7);
    top = 1; ack_vec(24'h000041, "R7 pair lifted", 7);
    top = 0; ack_vec(24'h000041, "R7 pair in slot", 1);
    pen = 1; psel = 23; ack_vec(24'h800041, "R8 promoted", 24);
    pen = 0; swp = 0;

    // R4: second write while iack high is ignored
    src = 24'h000100; iset = 1; cycle("R4 first");
    src = 24'h000001; iset = 1; cycle("R4 ignored");
    chk("R4 vec kept", vec, 9);
    chk("R10 vec hold", vec, 9);
    clr = '1; src = '0; cycle("R9 clr");

    // R9 nesting
    src = 24'h000400; iset = 1; cycle("R9 ack10");
    src = 24'h001400; cycle("R9 blocked");
    chk("R9 lower blocked", irq, 0);
    src = 24'h001408; cycle("R9 higher");
    chk("R9 higher passes", irq, N_LVL'(1) << lvl);
    // ack plus clear of winner on the same edge: set wins
    src = 24'h000008; iset = 1; clr = 24'h000008; cycle("R9 set beats clr");
    src = 24'h000010; cycle("R9 4 below 3");
    chk("R9 still in service", irq, 0);
    clr = 24'h000008; cycle("R9 clear 3");
    chk("R9 after clear", irq, N_LVL'(1) << lvl);
    clr = '1; src = '0; cycle("R9 clr all");

    for (int n = 0; n < 3000; n++) begin
      src  = $urandom & $urandom;
      mask = $urandom & $urandom & $urandom;
      if ($urandom_range(0, 15) == 0) begin
        lvl = LVL_W'($urandom); swp = 1'($urandom); top = 1'($urandom);
        pen = 1'($urandom); psel = SEL_W'($urandom_range(0, N_SRC - 1));
      end
      iset = ($urandom_range(0, 2) == 0);
      clr  = ($urandom_range(0, 3) == 0) ? N_SRC'($urandom) : '0;
      cycle("random");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule